// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-precision event timer, bundled with the free-running 64-bit main counter that the channel watches. Software reaches every register through a plain 32-bit register port: a write strobe, a byte address, write data, and read data that is a combinational function of the address. When the running counter reaches the value held in the comparator, the channel raises an event. One-shot and periodic scheduling are both supported, and the comparison can be limited to the low 32 bits.

The event leaves the block in one of three ways. In edge mode it is a one-cycle interrupt pulse. In level mode it is a sticky status bit that drives the interrupt line until software clears it. With message delivery enabled it is a posted message carrying the data and address words from the route registers. The message leaves through a valid/ready channel. `msg_valid` rises one clock after a match. From then on `msg_valid`, `msg_data` and `msg_addr` stay constant until a rising clock edge that sees `msg_ready` high. A match that arrives while an earlier message is still stalled adds no second message.

Register word map (byte address = word × 4):

| Word | Content |
|------|---------|
| 0 | identity, read-only |
| 1 | global control: bit 0 = run |
| 2 | channel status: bit 0 |
| 3 | counter, low half |
| 4 | counter, high half |
| 5 | channel setup |
| 6 | comparator, low half |
| 7 | comparator, high half |
| 8 | route: message data |
| 9 | route: message address |

Channel setup bits (word 5):

| Bit | Meaning |
|-----|---------|
| 0 | enable |
| 1 | level (1) or edge (0) |
| 2 | periodic |
| 3 | set-value |
| 4 | 32-bit compare |
| 5 | message delivery |
| 8 | periodic capability, read-only |
| 9 | message capability, read-only |

Top module: `evt_timer_channel`

## Requirements
- R1: After reset the global run bit, the channel setup bits 0 to 5, the counter, the channel status and both outputs `irq_out` and `msg_valid` are zero. The comparator reads back as all ones.
- R2: Word 0 reads as a fixed value. Bits [7:0] hold revision 8'h01, bits [12:8] hold NUM_CHAN minus one, and all other bits are zero.
- R3: While run (word 1 bit 0) is set, the counter increases by one on every clock. While run is clear, the counter holds its value. A write to word 3 or word 4 replaces that half of the counter and takes precedence over counting in that clock.
- R4: An event happens only in a clock in which the counter equals the comparator exactly. A comparator value that the counter has already passed produces no event.
- R5: A comparator or period write is applied one clock after the edge that accepts it. The edge pulse on `irq_out` is high for exactly the clock that follows the edge that ends the matching clock.
- R6: With word 5 bit 4 set, only the low 32 bits are compared. With that bit clear, all 64 bits must be equal.
- R7: With periodic (bit 2) and set-value (bit 3) both set, comparator writes load the match time. Set-value clears itself on a write to word 7, or on a write to word 6 when bit 4 is set. Later comparator writes load the period and leave the match time unchanged.
- R8: In periodic mode, each event adds the stored period to the comparator. The new value can be read back through words 6 and 7.
- R9: In edge mode, each event gives a single one-cycle pulse on `irq_out` and does not set the channel status.
- R10: In level mode, an event sets status (word 2 bit 0), and `irq_out` follows that status. Writing 1 to bit 0 clears it, and writing 0 has no effect.
- R11: With bit 5 set, an event posts a message carrying words 8 and 9 and gives no pulse on `irq_out`. The message obeys the valid/ready rules stated above.
- R12: Bits 8 and 9 of word 5 reflect the build-time capabilities, and writes to them are ignored.
- R13: No event occurs while the channel is disabled or the counter is stopped, even when the counter equals the comparator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock; also the counter clock |
| rst_n | input | 1 | asynchronous reset, active low |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | ADDR_W | register byte address |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for `reg_addr` |
| irq_out | output | 1 | interrupt line, pulse or level |
| msg_valid | output | 1 | message request valid |
| msg_ready | input | 1 | message sink ready |
| msg_data | output | 32 | message data word |
| msg_addr | output | 32 | message address word |

## Verification
The assertions check on every cycle the following behaviours:
- the counter steps by one or holds;
- the comparator changes only through a staged write or a periodic reload, and a reload adds exactly the period;
- set-value clears itself after the qualifying write;
- level status is sticky until cleared;
- a stalled message holds its fields.

Only the bench scenarios can show the rest: the exact clock of each event relative to counter start, whether a value already passed is missed, how 32-bit and 64-bit comparison differ, the sequence of reloads in periodic mode, and how delivery is chosen between pulse, level and message.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int WORD_W = 32;

  localparam logic [3:0] W_ID   = 4'd0;
  localparam logic [3:0] W_GCFG = 4'd1;
  localparam logic [3:0] W_STAT = 4'd2;
  localparam logic [3:0] W_CNTL = 4'd3;
  localparam logic [3:0] W_CNTH = 4'd4;
  localparam logic [3:0] W_CCFG = 4'd5;
  localparam logic [3:0] W_CMPL = 4'd6;
  localparam logic [3:0] W_CMPH = 4'd7;
  localparam logic [3:0] W_RTD  = 4'd8;
  localparam logic [3:0] W_RTA  = 4'd9;

  localparam int B_EN   = 0;
  localparam int B_LVL  = 1;
  localparam int B_PER  = 2;
  localparam int B_SETV = 3;
  localparam int B_N32  = 4;
  localparam int B_MSG  = 5;
  localparam int B_CPER = 8;
  localparam int B_CMSG = 9;

  localparam logic [7:0] REVISION = 8'h01;

  // packed so that enable lands on bit 0 and msg_en on bit 5
  typedef struct packed {
    logic msg_en;
    logic narrow;
    logic setv;
    logic periodic;
    logic level;
    logic enable;
  } chan_cfg_t;
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CNT_W = 64,
  parameter int HW    = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [HW-1:0]    wdata,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_lo) cnt[HW-1:0] <= wdata;
    else if (wr_hi) cnt[CNT_W-1:HW] <= wdata;
    else if (run)   cnt <= cnt + ONE;
  end

  // R3: counting step and hold
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_lo && !wr_hi) |=> cnt == $past(cnt) + ONE);
  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> $stable(cnt));
endmodule

// File: rtl/evt_comparator.sv
module evt_comparator #(
  parameter int CNT_W = 64,
  parameter int HW    = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             run,
  input  logic             enable,
  input  logic             periodic,
  input  logic             narrow,
  input  logic             setv,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [HW-1:0]    wdata,
  output logic             setv_clr,
  output logic             match,
  output logic [CNT_W-1:0] cmp_q
);
  logic          stg_v, stg_hi, stg_to_cmp;
  logic [HW-1:0] stg_d;
  logic [CNT_W-1:0] per_q;
  logic eq_lo, eq_hi;

  assign setv_clr = periodic && setv && (wr_hi || (wr_lo && narrow));
  assign eq_lo    = (cnt[HW-1:0] == cmp_q[HW-1:0]);
  assign eq_hi    = (cnt[CNT_W-1:HW] == cmp_q[CNT_W-1:HW]);
  assign match    = run && enable && eq_lo && (narrow || eq_hi);

  // one-clock write staging: fixed latency of one counter clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v      <= 1'b0;
      stg_hi     <= 1'b0;
      stg_to_cmp <= 1'b0;
      stg_d      <= '0;
    end else begin
      stg_v      <= wr_lo || wr_hi;
      stg_hi     <= wr_hi;
      stg_to_cmp <= !periodic || setv;
      stg_d      <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      per_q <= '0;
    end else if (stg_v) begin
      if (stg_to_cmp) begin
        if (stg_hi) cmp_q[CNT_W-1:HW] <= stg_d;
        else        cmp_q[HW-1:0]     <= stg_d;
      end else begin
        if (stg_hi) per_q[CNT_W-1:HW] <= stg_d;
        else        per_q[HW-1:0]     <= stg_d;
      end
    end else if (match && periodic) begin
      if (narrow) cmp_q[HW-1:0] <= cmp_q[HW-1:0] + per_q[HW-1:0];
      else        cmp_q         <= cmp_q + per_q;
    end
  end

  // R8: reload adds the period
  p_reload_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match && periodic && !narrow && !stg_v) |=> cmp_q == $past(cmp_q) + $past(per_q));
  // R4: comparator is untouched without a write or a periodic match
  p_cmp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stg_v && !(match && periodic)) |=> $stable(cmp_q));
  // R5: staged low write lands one clock later
  p_write_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_v && stg_to_cmp && !stg_hi) |=> cmp_q[HW-1:0] == $past(stg_d));
endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match,
  input  logic              level,
  input  logic              msg_en,
  input  logic              stat_clr,
  input  logic [WORD_W-1:0] rt_data,
  input  logic [WORD_W-1:0] rt_addr,
  input  logic              msg_ready,
  output logic              irq_out,
  output logic              stat_q,
  output logic              msg_valid,
  output logic [WORD_W-1:0] msg_data,
  output logic [WORD_W-1:0] msg_addr
);
  logic pulse_q;
  logic post;

  assign post    = match && msg_en && (!msg_valid || msg_ready);
  assign irq_out = level ? (stat_q && !msg_en) : pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      pulse_q <= match && !level && !msg_en;
      if (match && level) stat_q <= 1'b1;
      else if (stat_clr)  stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_data  <= '0;
      msg_addr  <= '0;
    end else if (post) begin
      msg_valid <= 1'b1;
      msg_data  <= rt_data;
      msg_addr  <= rt_addr;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R11: stalled message holds its fields
  p_msg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data) && $stable(msg_addr)));
  // R10: status sticky until cleared, cleared on request
  p_stat_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !stat_clr) |=> stat_q);
  p_stat_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !(match && level)) |=> !stat_q);
endmodule

// File: rtl/evt_timer_channel.sv
module evt_timer_channel
  import evt_pkg::*;
#(
  parameter int NUM_CHAN     = 3,
  parameter int CAP_PERIODIC = 1,
  parameter int CAP_MSG      = 1,
  parameter int ADDR_W       = 6,
  parameter int CNT_W        = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [31:0]       msg_data,
  output logic [31:0]       msg_addr
);
  localparam int HW = CNT_W / 2;
  localparam logic [4:0] CHAN_M1 = 5'(NUM_CHAN - 1);

  logic [3:0] widx;
  logic       unused_low;
  assign widx       = reg_addr[5:2];
  assign unused_low = ^reg_addr[1:0];

  logic wr_gcfg, wr_stat, wr_cntl, wr_cnth, wr_ccfg, wr_cmpl, wr_cmph, wr_rtd, wr_rta;
  assign wr_gcfg = reg_wr && (widx == W_GCFG);
  assign wr_stat = reg_wr && (widx == W_STAT);
  assign wr_cntl = reg_wr && (widx == W_CNTL);
  assign wr_cnth = reg_wr && (widx == W_CNTH);
  assign wr_ccfg = reg_wr && (widx == W_CCFG);
  assign wr_cmpl = reg_wr && (widx == W_CMPL);
  assign wr_cmph = reg_wr && (widx == W_CMPH);
  assign wr_rtd  = reg_wr && (widx == W_RTD);
  assign wr_rta  = reg_wr && (widx == W_RTA);

  logic per_ok, msg_ok;
  generate
    if (CAP_PERIODIC != 0) begin : g_per
      assign per_ok = 1'b1;
    end else begin : g_noper
      assign per_ok = 1'b0;
    end
    if (CAP_MSG != 0) begin : g_msg
      assign msg_ok = 1'b1;
    end else begin : g_nomsg
      assign msg_ok = 1'b0;
    end
  endgenerate

  chan_cfg_t  cfg_q;
  logic       run_q;
  logic [31:0] rt_data_q, rt_addr_q;
  logic       setv_clr, match, stat_q;
  logic [CNT_W-1:0] cnt, cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      cfg_q     <= '0;
      rt_data_q <= '0;
      rt_addr_q <= '0;
    end else begin
      if (wr_gcfg) run_q <= reg_wdata[0];
      if (wr_rtd)  rt_data_q <= reg_wdata;
      if (wr_rta)  rt_addr_q <= reg_wdata;
      if (wr_ccfg) begin
        cfg_q.enable   <= reg_wdata[B_EN];
        cfg_q.level    <= reg_wdata[B_LVL];
        cfg_q.periodic <= reg_wdata[B_PER] & per_ok;
        cfg_q.setv     <= reg_wdata[B_SETV] & per_ok;
        cfg_q.narrow   <= reg_wdata[B_N32];
        cfg_q.msg_en   <= reg_wdata[B_MSG] & msg_ok;
      end else if (setv_clr) begin
        cfg_q.setv <= 1'b0;
      end
    end
  end

  evt_main_counter #(.CNT_W(CNT_W), .HW(HW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q),
    .wr_lo(wr_cntl), .wr_hi(wr_cnth), .wdata(reg_wdata), .cnt(cnt)
  );

  evt_comparator #(.CNT_W(CNT_W), .HW(HW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .run(run_q),
    .enable(cfg_q.enable), .periodic(cfg_q.periodic), .narrow(cfg_q.narrow),
    .setv(cfg_q.setv), .wr_lo(wr_cmpl), .wr_hi(wr_cmph), .wdata(reg_wdata),
    .setv_clr(setv_clr), .match(match), .cmp_q(cmp_q)
  );

  evt_irq_out #(.WORD_W(32)) u_out (
    .clk(clk), .rst_n(rst_n), .match(match), .level(cfg_q.level),
    .msg_en(cfg_q.msg_en), .stat_clr(wr_stat && reg_wdata[0]),
    .rt_data(rt_data_q), .rt_addr(rt_addr_q), .msg_ready(msg_ready),
    .irq_out(irq_out), .stat_q(stat_q), .msg_valid(msg_valid),
    .msg_data(msg_data), .msg_addr(msg_addr)
  );

  always_comb begin
    reg_rdata = '0;
    case (widx)
      W_ID:   reg_rdata = {19'd0, CHAN_M1, REVISION};
      W_GCFG: reg_rdata[0] = run_q;
      W_STAT: reg_rdata[0] = stat_q;
      W_CNTL: reg_rdata = cnt[HW-1:0];
      W_CNTH: reg_rdata = cnt[CNT_W-1:HW];
      W_CCFG: begin
        reg_rdata[5:0]    = cfg_q;
        reg_rdata[B_CPER] = per_ok;
        reg_rdata[B_CMSG] = msg_ok;
      end
      W_CMPL: reg_rdata = cmp_q[HW-1:0];
      W_CMPH: reg_rdata = cmp_q[CNT_W-1:HW];
      W_RTD:  reg_rdata = rt_data_q;
      W_RTA:  reg_rdata = rt_addr_q;
      default: reg_rdata = '0;
    endcase
  end

  // R7: set-value bit drops after the qualifying write
  p_setv_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmph && cfg_q.periodic && cfg_q.setv) |=> !cfg_q.setv);
  // R13: no event output while stopped
  p_quiet_stopped_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cfg_q.level && !msg_valid) |=> !msg_valid);
endmodule

// File: tb/sim_evt_timer_channel.sv
module sim_evt_timer_channel;
  import evt_pkg::*;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_out, msg_valid, msg_ready;
  logic [31:0] msg_data, msg_addr;

  int total = 0, bad = 0, edges = 0;
  bit watch_irq = 1'b1;
  bit done = 1'b0;
  int exp_irq[$];
  logic [63:0] exp_msg[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  evt_timer_channel u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
    .msg_addr(msg_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {idx, 2'b00}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_addr = {idx, 2'b00};
    #1 d = reg_rdata;
  endtask

  task automatic wait_until(input int e);
    while (edges < e) @(negedge clk);
  endtask

  task automatic start_run(output int ew);
    wr(W_GCFG, 32'd1);
    ew = edges;
  endtask

  task automatic halt_clear;
    wr(W_GCFG, 32'd0);
    wr(W_CNTL, 32'd0);
    wr(W_CNTH, 32'd0);
  endtask

  // monitor: scoreboard for pulses and messages
  always @(negedge clk) begin : mon
    int e;
    logic [63:0] m;
    #2;
    if (rst_n && watch_irq && irq_out) begin
      if (exp_irq.size() == 0) chk(1'b0, "R9 unexpected pulse", edges, 0);
      else begin
        e = exp_irq.pop_front();
        chk(e == edges, "R5 pulse clock", edges, e);
      end
    end
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_msg.size() == 0) chk(1'b0, "R11 unexpected message", {msg_data, msg_addr}, 0);
      else begin
        m = exp_msg.pop_front();
        chk({msg_data, msg_addr} == m, "R11 message fields", {msg_data, msg_addr}, m);
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 60000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int ew, es;
    msg_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2 / R12 reset state
    #1 chk(irq_out == 1'b0 && msg_valid == 1'b0, "R1 outputs idle", {irq_out, msg_valid}, 0);
    rd(W_ID, v);   chk(v == 32'h0000_0201, "R2 identity word", v, 32'h201);
    rd(W_CCFG, v); chk(v == 32'h300, "R1 setup reset", v, 32'h300);
    rd(W_CMPL, v); chk(v == 32'hffff_ffff, "R1 comparator reset", v, 32'hffff_ffff);
    rd(W_CNTL, v); chk(v == 0, "R1 counter reset", v, 0);
    rd(W_STAT, v); chk(v == 0, "R1 status reset", v, 0);
    wr(W_CCFG, 32'h0);
    rd(W_CCFG, v); chk(v == 32'h300, "R12 capability bits read-only", v, 32'h300);

    // R3 counting, stop, half writes
    start_run(ew);
    repeat (7) @(negedge clk);
    rd(W_CNTL, v); chk(v == edges - ew, "R3 counting", v, edges - ew);
    wr(W_GCFG, 32'd0); es = edges;
    repeat (5) @(negedge clk);
    rd(W_CNTL, v); chk(v == es - ew, "R3 hold when stopped", v, es - ew);
    wr(W_CNTH, 32'h7);
    rd(W_CNTH, v); chk(v == 32'h7, "R3 high half write", v, 7);
    halt_clear;
    rd(W_CNTL, v); chk(v == 0, "R3 counter cleared", v, 0);

    // R13 stopped counter equal to comparator
    wr(W_CMPL, 32'd0); wr(W_CMPH, 32'd0); wr(W_CCFG, 32'h1);
    repeat (10) @(negedge clk);
    chk(exp_irq.size() == 0 && irq_out == 1'b0, "R13 stopped no event", irq_out, 0);

    // R4 / R5 / R9 one-shot edge, 64-bit
    wr(W_CMPL, 32'd40);
    start_run(ew);
    exp_irq.push_back(ew + 41);
    wait_until(ew + 60);
    chk(exp_irq.size() == 0, "R4 match event seen", exp_irq.size(), 0);
    rd(W_STAT, v); chk(v == 0, "R9 edge mode leaves status clear", v, 0);
    halt_clear;

    // R4 value already passed
    wr(W_CNTL, 32'd100); wr(W_CMPL, 32'd50);
    start_run(ew);
    wait_until(ew + 40);
    wr(W_GCFG, 32'd0); es = edges;
    rd(W_CNTL, v); chk(v == 100 + es - ew, "R4 past value missed, counter ran", v, 100 + es - ew);
    halt_clear;

    // R6 width of compare
    wr(W_CMPH, 32'd1); wr(W_CMPL, 32'd20);
    start_run(ew);
    wait_until(ew + 40);
    halt_clear;
    chk(exp_irq.size() == 0, "R6 64-bit mismatch silent", exp_irq.size(), 0);
    wr(W_CCFG, 32'h11);
    start_run(ew);
    exp_irq.push_back(ew + 21);
    wait_until(ew + 30);
    halt_clear;
    chk(exp_irq.size() == 0, "R6 32-bit match", exp_irq.size(), 0);

    // R7 / R8 periodic
    wr(W_CCFG, 32'h0D);
    wr(W_CMPL, 32'd30); wr(W_CMPH, 32'd0);
    rd(W_CCFG, v); chk(v == 32'h305, "R7 set-value self-clear", v, 32'h305);
    wr(W_CMPL, 32'd25); wr(W_CMPH, 32'd0);
    rd(W_CMPL, v); chk(v == 32'd30, "R7 period write keeps match time", v, 30);
    start_run(ew);
    exp_irq.push_back(ew + 31); exp_irq.push_back(ew + 56); exp_irq.push_back(ew + 81);
    wait_until(ew + 90);
    wr(W_GCFG, 32'd0);
    chk(exp_irq.size() == 0, "R8 periodic events", exp_irq.size(), 0);
    rd(W_CMPL, v); chk(v == 32'd105, "R8 comparator advanced", v, 105);
    halt_clear;

    // R10 level mode
    watch_irq = 1'b0;
    wr(W_CCFG, 32'h03);
    wr(W_CMPL, 32'd10); wr(W_CMPH, 32'd0);
    start_run(ew);
    wait_until(ew + 15);
    #1 chk(irq_out == 1'b1, "R10 level line high", irq_out, 1);
    rd(W_STAT, v); chk(v == 1, "R10 status set", v, 1);
    wr(W_STAT, 32'd0);
    #1 chk(irq_out == 1'b1, "R10 write zero ignored", irq_out, 1);
    wr(W_STAT, 32'd1);
    #1 chk(irq_out == 1'b0, "R10 write one clears", irq_out, 0);
    halt_clear;
    wr(W_CCFG, 32'h0);
    watch_irq = 1'b1;

    // R11 message delivery with back-pressure
    wr(W_RTD, 32'hA5A5_0001); wr(W_RTA, 32'hFEE0_0000);
    wr(W_CCFG, 32'h21);
    wr(W_CMPL, 32'd12);
    start_run(ew);
    wait_until(ew + 20);
    #1 chk(msg_valid == 1'b1, "R11 message posted", msg_valid, 1);
    repeat (3) @(negedge clk);
    #1 chk(msg_valid && msg_data == 32'hA5A5_0001 && msg_addr == 32'hFEE0_0000,
           "R11 stalled message held", {msg_data, msg_addr}, 64'hA5A5_0001_FEE0_0000);
    exp_msg.push_back(64'hA5A5_0001_FEE0_0000);
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
    #1 chk(msg_valid == 1'b0, "R11 released after transfer", msg_valid, 0);
    chk(exp_msg.size() == 0, "R11 transfer seen", exp_msg.size(), 0);
    halt_clear;

    // R13 disabled channel while running
    wr(W_CCFG, 32'h0); wr(W_CMPL, 32'd8);
    start_run(ew);
    wait_until(ew + 30);
    halt_clear;
    chk(exp_irq.size() == 0 && irq_out == 1'b0, "R13 disabled no event", irq_out, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule